// File: doc/BRIEF.md
# Serial Configuration Port with Power-Mode Wake

This block is a write-only three-wire serial slave that sits in the system clock domain. A host frames a transfer with an active-low select line, toggles a serial clock and presents data on a single input. The block first resynchronises the three lines through two-flop synchronisers. It then finds edges on the synchronised copies and shifts in 16-bit command words, most significant bit first, on each rising serial-clock edge while select is low. When select rises, a word is accepted only if exactly 16 bits arrived. Bits 15..12 of the word are a register address and bits 11..0 are data. Addresses outside the map are accepted and have no effect.

The power mode is the state of a six-state machine: `PM_SHDN`, `PM_IDLE`, `PM_STBY`, `PM_RX`, `PM_TX`, `PM_FD`. From any active state, a valid mode write (`MODE_WRITE`) moves the machine to the coded state, and code 0 moves it to `PM_SHDN`. In `PM_SHDN` the machine watches only select. Any select rising edge (`WAKE`) moves it to the state held in the wake register. Every bit shifted with that pulse is discarded, and all settings survive the shutdown. After each mode change a ready output stays low for a programmable settling count. The count is `WAKE_CYC` cycles when leaving shutdown and `SWITCH_CYC` cycles for any other change. Both counts must be at least 1.

Top module: `cfgw_port`

## Requirements
- R1: After reset the mode output is 0 (shutdown), the wake register and all four 12-bit settings are 0, and ready is low.
- R2: In an active mode, a 16-bit word shifted MSB first is applied when select rises. Address 1 loads the wake register from data bits 2..0. Addresses 2, 3, 4 and 5 load transmit offset, transmit common-mode, auxiliary DAC and auxiliary ADC state from data bits 11..0.
- R3: A transfer that ends with fewer or more than 16 rising serial-clock edges changes no register and no mode.
- R4: A word with address 6 through 15 changes no register and no mode.
- R5: Address 0 with data bits 2..0 equal to 0..5 sets the mode: 0 shutdown, 1 idle, 2 standby, 3 receive, 4 transmit, 5 full duplex. Codes 6 and 7 are ignored.
- R6: In shutdown, a select rising edge leaves shutdown whatever bits were shifted with it, and it changes no register.
- R7: On wake the mode becomes the wake register value when that value is 1..5, and otherwise becomes idle.
- R8: The wake register and all four settings hold their pre-shutdown values after wake.
- R9: After wake, ready is low for exactly WAKE_CYC cycles and then rises.
- R10: After a mode change between non-shutdown modes, ready is low for exactly SWITCH_CYC cycles. In shutdown, ready is low.
- R11: A transfer works whether the serial clock idles high or low between transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_sel_n | input | 1 | Active-low select; also the wake line |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, sampled on serial-clock rise |
| pmode_o | output | 3 | Current power mode code |
| ready_o | output | 1 | High once the settling count has elapsed in an active mode |
| wake_mode_o | output | 3 | Wake register |
| tx_offset_o | output | 12 | Transmit offset setting |
| tx_cmode_o | output | 12 | Transmit common-mode setting |
| aux_dac_o | output | 12 | Auxiliary DAC setting |
| aux_adc_o | output | 12 | Auxiliary ADC state setting |

## Verification
On every cycle the assertions check four properties: the mode code stays legal, ready is low in shutdown and in the cycle of any mode change, nothing in the register bank moves while in shutdown, and leaving shutdown always lands in the wake target. Only the bench scenarios can show the rest. That includes MSB-first word assembly, rejection of short, long and unmapped words, the exact length of each settling window, and transfers with either serial-clock idle level. These are checked against a reference model of the register map under random and directed traffic.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 12;
    localparam int MODE_W = 3;
    localparam int NSET   = 4;

    typedef enum logic [MODE_W-1:0] {
        PM_SHDN = 3'd0,
        PM_IDLE = 3'd1,
        PM_STBY = 3'd2,
        PM_RX   = 3'd3,
        PM_TX   = 3'd4,
        PM_FD   = 3'd5
    } pmode_e;

    localparam logic [ADDR_W-1:0] A_PMODE = 4'd0;
    localparam logic [ADDR_W-1:0] A_WAKE  = 4'd1;
    localparam logic [ADDR_W-1:0] A_SET0  = 4'd2;

    function automatic logic code_ok(input logic [MODE_W-1:0] c);
        return c <= 3'd5;
    endfunction
endpackage

// File: rtl/cfgw_sync.sv
module cfgw_sync #(
    parameter int           W    = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= INIT;
            q    <= INIT;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cfgw_shift.sv
module cfgw_shift
    import cfgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_s,
    input  logic              sck_s,
    input  logic              dat_s,
    output logic              sel_rise,
    output logic              word_ok,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W) + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] SAT  = '1;

    logic             sel_q, sck_q;
    logic [CNT_W-1:0] cnt;
    logic             sel_fall, sck_rise;

    assign sel_fall = sel_q & ~sel_s;
    assign sel_rise = sel_s & ~sel_q;
    assign sck_rise = sck_s & ~sck_q;
    assign word_ok  = sel_rise && (cnt == FULL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 1'b1;
            sck_q <= 1'b0;
            cnt   <= '0;
            word  <= '0;
        end else begin
            sel_q <= sel_s;
            sck_q <= sck_s;
            if (sel_fall) begin
                cnt  <= '0;
                word <= '0;
            end else if (!sel_s && sck_rise) begin
                word <= {word[WORD_W-2:0], dat_s};
                if (cnt != SAT) cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfgw_regs.sv
module cfgw_regs
    import cfgw_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [WORD_W-1:0]           word,
    output logic                        mode_wr,
    output logic [MODE_W-1:0]           mode_code,
    output logic [MODE_W-1:0]           wake_sel,
    output logic [NSET-1:0][DATA_W-1:0] set_o
);
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;

    assign addr      = word[WORD_W-1 -: ADDR_W];
    assign data      = word[DATA_W-1:0];
    assign mode_code = data[MODE_W-1:0];
    assign mode_wr   = wr_en && (addr == A_PMODE) && code_ok(mode_code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          wake_sel <= '0;
        else if (wr_en && addr == A_WAKE)    wake_sel <= data[MODE_W-1:0];
    end

    for (genvar i = 0; i < NSET; i++) begin : g_set
        localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(int'(A_SET0) + i);
        logic [DATA_W-1:0] r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    r <= '0;
            else if (wr_en && addr == MY_A) r <= data;
        end
        assign set_o[i] = r;
    end
endmodule

// File: rtl/cfgw_pwr.sv
module cfgw_pwr
    import cfgw_pkg::*;
#(
    parameter int WAKE_CYC   = 40,
    parameter int SWITCH_CYC = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_rise,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_code,
    input  logic [MODE_W-1:0] wake_sel,
    output logic [MODE_W-1:0] mode_o,
    output logic              ready_o
);
    localparam int SMAX   = (WAKE_CYC > SWITCH_CYC) ? WAKE_CYC : SWITCH_CYC;
    localparam int SCNT_W = $clog2(SMAX + 1);
    localparam logic [SCNT_W-1:0] LD_WAKE = SCNT_W'(WAKE_CYC);
    localparam logic [SCNT_W-1:0] LD_SW   = SCNT_W'(SWITCH_CYC);

    pmode_e            state_q, state_d, wake_tgt;
    logic [SCNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        if (wake_sel != 3'd0 && code_ok(wake_sel)) wake_tgt = pmode_e'(wake_sel);
        else                                       wake_tgt = PM_IDLE;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_SHDN: if (sel_rise) state_d = wake_tgt;
            PM_IDLE, PM_STBY, PM_RX, PM_TX, PM_FD:
                if (mode_wr) state_d = pmode_e'(mode_code);
            default: state_d = PM_SHDN;
        endcase
    end

    always_comb begin
        cnt_d = cnt_q;
        if (state_d != state_q) begin
            if (state_d == PM_SHDN)      cnt_d = '0;
            else if (state_q == PM_SHDN) cnt_d = LD_WAKE;
            else                         cnt_d = LD_SW;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PM_SHDN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        mode_o  = state_q;
        ready_o = (state_q != PM_SHDN) && (cnt_q == '0);
    end
endmodule

// File: rtl/cfgw_port.sv
module cfgw_port
    import cfgw_pkg::*;
#(
    parameter int WAKE_CYC   = 40,
    parameter int SWITCH_CYC = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_sel_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic [MODE_W-1:0] pmode_o,
    output logic              ready_o,
    output logic [MODE_W-1:0] wake_mode_o,
    output logic [DATA_W-1:0] tx_offset_o,
    output logic [DATA_W-1:0] tx_cmode_o,
    output logic [DATA_W-1:0] aux_dac_o,
    output logic [DATA_W-1:0] aux_adc_o
);
    logic [2:0]                  pins_s;
    logic                        sel_rise, word_ok, mode_wr;
    logic [WORD_W-1:0]           word;
    logic [MODE_W-1:0]           mode_code;
    logic [NSET-1:0][DATA_W-1:0] set_v;

    cfgw_sync #(.W(3), .INIT(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ser_sel_n, ser_clk, ser_dat}), .q(pins_s)
    );

    cfgw_shift u_shift (
        .clk(clk), .rst_n(rst_n),
        .sel_s(pins_s[2]), .sck_s(pins_s[1]), .dat_s(pins_s[0]),
        .sel_rise(sel_rise), .word_ok(word_ok), .word(word)
    );

    cfgw_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(word_ok && (pmode_o != PM_SHDN)),
        .word(word), .mode_wr(mode_wr), .mode_code(mode_code),
        .wake_sel(wake_mode_o), .set_o(set_v)
    );

    cfgw_pwr #(.WAKE_CYC(WAKE_CYC), .SWITCH_CYC(SWITCH_CYC)) u_pwr (
        .clk(clk), .rst_n(rst_n),
        .sel_rise(sel_rise), .mode_wr(mode_wr), .mode_code(mode_code),
        .wake_sel(wake_mode_o), .mode_o(pmode_o), .ready_o(ready_o)
    );

    assign tx_offset_o = set_v[0];
    assign tx_cmode_o  = set_v[1];
    assign aux_dac_o   = set_v[2];
    assign aux_adc_o   = set_v[3];
endmodule

// File: rtl/cfgw_port_chk.sv
module cfgw_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  pmode_o,
    input logic        ready_o,
    input logic [2:0]  wake_mode_o,
    input logic [11:0] tx_offset_o,
    input logic [11:0] tx_cmode_o,
    input logic [11:0] aux_dac_o,
    input logic [11:0] aux_adc_o
);
    logic [2:0]  tgt;
    logic [50:0] bank;

    assign tgt  = (wake_mode_o >= 3'd1 && wake_mode_o <= 3'd5) ? wake_mode_o : 3'd1;
    assign bank = {wake_mode_o, tx_offset_o, tx_cmode_o, aux_dac_o, aux_adc_o};

    p_mode_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pmode_o <= 3'd5);

    p_ready_shdn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pmode_o == 3'd0) |-> !ready_o);

    p_bank_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pmode_o == 3'd0) |=> $stable(bank));

    p_wake_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pmode_o == 3'd0) |=> (pmode_o == 3'd0 || pmode_o == $past(tgt)));

    p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pmode_o) |-> !ready_o);
endmodule

bind cfgw_port cfgw_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pmode_o(pmode_o), .ready_o(ready_o),
    .wake_mode_o(wake_mode_o), .tx_offset_o(tx_offset_o),
    .tx_cmode_o(tx_cmode_o), .aux_dac_o(aux_dac_o), .aux_adc_o(aux_adc_o)
);

// File: tb/cfgw_port_tb.sv
module cfgw_port_tb;
    localparam int WAKE_N = 40;
    localparam int SW_N   = 12;
    localparam int H      = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sel_n = 1'b1, sck = 1'b0, sdat = 1'b0;
    logic [2:0]  pmode_o, wake_mode_o;
    logic        ready_o;
    logic [11:0] tx_offset_o, tx_cmode_o, aux_dac_o, aux_adc_o;

    int checks = 0, fails = 0;
    int run = 0, last_run = -1;
    bit tracking = 0;
    logic [2:0]  prev_mode = 3'd0;
    logic [2:0]  m_mode = 3'd0, m_wake = 3'd0;
    logic [11:0] m_set [4] = '{default: 12'd0};

    always #4 clk = ~clk;

    cfgw_port #(.WAKE_CYC(WAKE_N), .SWITCH_CYC(SW_N)) u_dut (
        .clk(clk), .rst_n(rst_n), .ser_sel_n(sel_n), .ser_clk(sck), .ser_dat(sdat),
        .pmode_o(pmode_o), .ready_o(ready_o), .wake_mode_o(wake_mode_o),
        .tx_offset_o(tx_offset_o), .tx_cmode_o(tx_cmode_o),
        .aux_dac_o(aux_dac_o), .aux_adc_o(aux_adc_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (pmode_o != prev_mode) begin tracking = 1; run = 0; end
            if (tracking) begin
                if (!ready_o) run++;
                else begin tracking = 0; last_run = run; end
            end
            prev_mode = pmode_o;
        end
    end

    function automatic logic [2:0] wake_tgt(input logic [2:0] w);
        return (w >= 3'd1 && w <= 3'd5) ? w : 3'd1;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w, input int nbits, input bit idle_hi);
        @(negedge clk); sck = idle_hi; sel_n = 1'b0;
        repeat (2*H) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sck = 1'b0; sdat = w[15 - (i % 16)];
            repeat (H) @(negedge clk);
            sck = 1'b1;
            repeat (H) @(negedge clk);
        end
        sck = idle_hi;
        repeat (H) @(negedge clk);
        sel_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic op(input string req, input logic [15:0] w, input int nbits, input bit idle_hi);
        logic [2:0] pm;
        logic [3:0] a;
        pm = m_mode;
        a  = w[15:12];
        if (m_mode == 3'd0) m_mode = wake_tgt(m_wake);
        else if (nbits == 16) begin
            if (a == 4'd0 && w[2:0] <= 3'd5) m_mode = w[2:0];
            else if (a == 4'd1) m_wake = w[2:0];
            else if (a >= 4'd2 && a <= 4'd5) m_set[a-2] = w[11:0];
        end
        last_run = -1;
        send(w, nbits, idle_hi);
        chk(req, {pmode_o, wake_mode_o, tx_offset_o, tx_cmode_o, aux_dac_o, aux_adc_o},
                 {m_mode, m_wake, m_set[0], m_set[1], m_set[2], m_set[3]});
        if (m_mode != pm) begin
            repeat (WAKE_N + 20) @(negedge clk);
            if (m_mode == 3'd0) chk({req, " R10 ready in shutdown"}, 64'(ready_o), 64'd0);
            else chk({req, (pm == 3'd0) ? " R9 wake settle" : " R10 switch settle"},
                     64'(last_run), 64'((pm == 3'd0) ? WAKE_N : SW_N));
        end else begin
            chk({req, " ready level"}, 64'(ready_o), 64'(m_mode != 3'd0));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        chk("R1 reset state", {ready_o, pmode_o, wake_mode_o, tx_offset_o, tx_cmode_o, aux_dac_o, aux_adc_o}, 64'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        op("R6 R7 wake with data ignored", 16'h2ABC, 16, 0);
        op("R2 offset write", 16'h2A5C, 16, 0);
        op("R2 wake reg write", 16'h1004, 16, 0);
        op("R2 aux adc write", 16'h5F0F, 16, 0);
        op("R3 short word", 16'h3123, 15, 0);
        op("R3 long word", 16'h3123, 17, 0);
        op("R4 unknown addr", 16'hB777, 16, 0);
        op("R5 mode rx", 16'h0003, 16, 0);
        op("R5 mode tx", 16'h0004, 16, 0);
        op("R5 code 7 ignored", 16'h0007, 16, 0);
        op("R11 idle high clock", 16'h3456, 16, 1);
        op("R10 shutdown entry", 16'h0000, 16, 0);
        op("R8 R6 wake keeps settings", 16'h0005, 16, 0);
        op("R5 full duplex", 16'h0FF5, 16, 1);
        for (int k = 0; k < 70; k++) begin
            int r;
            logic [15:0] w;
            r = int'($urandom % 10);
            w = 16'($urandom);
            if (r < 4)       op("R2 random reg", {4'(1 + $urandom % 5), w[11:0]}, 16, w[12]);
            else if (r == 4) op("R4 random unknown", {4'(6 + $urandom % 10), w[11:0]}, 16, 0);
            else if (r == 5) op("R3 random bad count", w, ($urandom % 2) ? int'(1 + $urandom % 15) : int'(17 + $urandom % 4), 0);
            else if (r < 8)  op("R5 random mode", {13'd0, 3'(1 + $urandom % 7)}, 16, w[0]);
            else if (r == 8) op("R10 random shutdown", 16'h0000, 16, 0);
            else             op("R6 random pulse", w, int'($urandom % 17), w[1]);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule